// File: doc/BRIEF.md
# Privileged Trap Entry and Return Controller

This block steers the program counter whenever a fault is taken or a return from a trap handler is requested. A five-bit fault code is looked up in a fixed vector table. The table gives an offset, which is added to a writable handler base register to form the new PC. The block also keeps the exception restart address. The privilege state is carried in bit 0 of the current PC: a value of 1 means privileged mode. That same bit, stored in the saved exception address, decides whether a return drops back out of shadow mode.

The block holds the integer register file together with an eight-entry shadow bank. The bank covers registers 8 to 14 and register 25. When the block enters shadow mode, those eight registers trade contents with the bank in one clock. Leaving shadow mode trades them back. Every other register keeps its contents. A swap requested into the state the bank is already in is reported on an error output and leaves the bank alone. A control register with a fixed reset value sits beside the base register.

Top module: `trap_steer`

## Requirements
- R1: After reset the outputs are as follows. pc_o equals RESET_BASE + 1 and npc_o equals pc_o + 4. shadow_o is 1, base_o is RESET_BASE, ctl_o is 6 and exc_addr_o is 0. redirect_o, swap_err_o, bad_rti_o and irq_chk_o are all 0.
- R2: A fault is accepted when flt_valid is 1 and flt_code is a known code. In the cycle after an accepted fault, pc_o equals base + offset, npc_o equals pc_o + 4 and redirect_o pulses for one cycle. The codes and offsets are:
  - 1 reset 0x0001
  - 2 machine check 0x0401
  - 3 arithmetic 0x0501
  - 4 interrupt 0x0101
  - 5 native data-map miss 0x0201
  - 6 privileged data-map miss 0x0281
  - 7 alignment 0x0301
  - 8 data-map fault 0x0381
  - 9 data access violation 0x0381
  - 10 instruction-map miss 0x0181
  - 11 instruction-map fault 0x0181
  - 12 instruction access violation 0x0081
  - 13 unimplemented opcode 0x0481
  - 14 FP disabled 0x0581
  - 15 privileged call 0x2001
  - 16 integer overflow 0x0501
- R3: On an accepted fault, exc_addr_o captures cur_pc. For codes 3, 15 and 16 it captures cur_pc + 4 instead.
- R4: An interrupt fault (code 4) taken while cur_pc[0] is 1 leaves exc_addr_o unchanged.
- R5: A fault taken while cur_pc[0] is 0 swaps the shadow bank in, so shadow_o becomes 1 and registers 8–14 and 25 exchange contents with the bank. A fault taken while cur_pc[0] is 1 requests no swap.
- R6: A return request (rti_req) while cur_pc[0] is 1 sets pc_o to exc_addr_o and npc_o to exc_addr_o + 4, and pulses irq_chk_o. The bank is swapped out (shadow_o becomes 0) only if bit 0 of exc_addr_o is 0.
- R7: A return request while cur_pc[0] is 0 pulses bad_rti_o and takes the unimplemented-opcode trap (offset 0x0481) as in R2, R3 and R5. irq_chk_o stays 0.
- R8: A swap requested into the state the bank already has pulses swap_err_o for one cycle. shadow_o and all register contents are left unchanged.
- R9: An accepted fault has priority over rti_req in the same cycle. flt_valid with code 0 or with a code above 16 has no effect.
- R10: base_we loads base_wdata into base_o, and later traps use the new base. ctl_we loads ctl_wdata into ctl_o.
- R11: rf_we writes rf_wdata to register rf_waddr, and rf_rdata shows register rf_raddr combinationally. Registers other than 8–14 and 25 are never changed by a swap. All eight redirected registers are exchanged in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault request this cycle |
| flt_code | input | 5 | Fault code (see R2) |
| cur_pc | input | AW | Current PC; bit 0 marks privileged mode |
| rti_req | input | 1 | Return-from-trap request |
| base_we | input | 1 | Base register write enable |
| base_wdata | input | AW | Base register write data |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | DW | Control register write data |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | RW | Register file write index |
| rf_wdata | input | DW | Register file write data |
| rf_raddr | input | RW | Register file read index |
| rf_rdata | output | DW | Register file read data |
| pc_o | output | AW | Steered PC |
| npc_o | output | AW | Next PC after pc_o |
| redirect_o | output | 1 | One-cycle pulse when pc_o was steered |
| exc_addr_o | output | AW | Saved exception address |
| shadow_o | output | 1 | Shadow bank currently swapped in |
| swap_err_o | output | 1 | Redundant swap request seen |
| bad_rti_o | output | 1 | Return requested outside privileged mode |
| irq_chk_o | output | 1 | Interrupt checking re-enabled by a return |
| base_o | output | AW | Handler base register |
| ctl_o | output | DW | Control register |

## Verification
The assertions assume that fault and return requests are qualified only by the cycle in which they appear. They also assume that cur_pc[0] is the privilege indication, so a return with flt_valid low is judged only by that bit. The bench drives every request for exactly one clock, changing inputs on the falling edge, and it never writes the register file during a swap cycle. The table walk issues every fault code from a privileged PC, so that the vector and restart-address checks are not mixed with swap effects. Swap ordering, redundant swaps and bad returns are then covered by directed sequences that start from a fresh reset.

// File: rtl/trap_pkg.sv
package trap_pkg;

   typedef enum logic [4:0] {
      FC_NONE     = 5'd0,
      FC_RESET    = 5'd1,
      FC_MCHK     = 5'd2,
      FC_ARITH    = 5'd3,
      FC_INTR     = 5'd4,
      FC_DMISS_N  = 5'd5,
      FC_DMISS_P  = 5'd6,
      FC_ALIGN    = 5'd7,
      FC_DFAULT   = 5'd8,
      FC_DACV     = 5'd9,
      FC_IMISS    = 5'd10,
      FC_IFAULT   = 5'd11,
      FC_IACV     = 5'd12,
      FC_UNIMPL   = 5'd13,
      FC_FPDIS    = 5'd14,
      FC_PRIVCALL = 5'd15,
      FC_IOVF     = 5'd16
   } fault_e;

   localparam int unsigned FC_LAST  = 16;
   localparam int unsigned VEC_W    = 16;
   localparam int unsigned NSHADOW  = 8;

   function automatic logic code_known(input logic [4:0] c);
      return (c != 5'd0) && (32'(c) <= FC_LAST);
   endfunction

   function automatic logic is_redir(input int idx);
      return ((idx >= 8) && (idx <= 14)) || (idx == 25);
   endfunction

endpackage

// File: rtl/trap_vector.sv
module trap_vector
   import trap_pkg::*;
(
   input  fault_e            code,
   output logic [VEC_W-1:0]  offset,
   output logic              skip
);

   always_comb begin
      offset = '0;
      unique case (code)
         FC_RESET:                offset = 16'h0001;
         FC_MCHK:                 offset = 16'h0401;
         FC_ARITH, FC_IOVF:       offset = 16'h0501;
         FC_INTR:                 offset = 16'h0101;
         FC_DMISS_N:              offset = 16'h0201;
         FC_DMISS_P:              offset = 16'h0281;
         FC_ALIGN:                offset = 16'h0301;
         FC_DFAULT, FC_DACV:      offset = 16'h0381;
         FC_IMISS, FC_IFAULT:     offset = 16'h0181;
         FC_IACV:                 offset = 16'h0081;
         FC_UNIMPL:               offset = 16'h0481;
         FC_FPDIS:                offset = 16'h0581;
         FC_PRIVCALL:             offset = 16'h2001;
         default:                 offset = '0;
      endcase
   end

   assign skip = (code == FC_ARITH) || (code == FC_IOVF) || (code == FC_PRIVCALL);

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
   import trap_pkg::*;
#(
   parameter int unsigned DW   = 32,
   parameter int unsigned NREG = 32,
   localparam int unsigned RW  = $clog2(NREG)
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           swap,
   input  logic           we,
   input  logic [RW-1:0]  waddr,
   input  logic [DW-1:0]  wdata,
   input  logic [RW-1:0]  raddr,
   output logic [DW-1:0]  rdata
);

   logic [DW-1:0] rd_arr [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic hit;
      assign hit = we && (waddr == RW'(i));
      if (is_redir(i)) begin : g_pair
         logic [DW-1:0] live_q, alt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               live_q <= '0;
               alt_q  <= '0;
            end else begin
               if (swap) begin
                  live_q <= alt_q;
                  alt_q  <= live_q;
               end
               if (hit) live_q <= wdata;
            end
         end
         assign rd_arr[i] = live_q;
      end else begin : g_plain
         logic [DW-1:0] live_q;
         always_ff @(posedge clk) begin
            if (!rst_n)   live_q <= '0;
            else if (hit) live_q <= wdata;
         end
         assign rd_arr[i] = live_q;
      end
   end

   assign rdata = rd_arr[raddr];

endmodule

// File: rtl/trap_seq.sv
module trap_seq
   import trap_pkg::*;
#(
   parameter int unsigned      AW         = 32,
   parameter int unsigned      DW         = 32,
   parameter logic [AW-1:0]    RESET_BASE = 32'h0000_4000,
   parameter logic [DW-1:0]    CTL_INIT   = 32'h6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_trap,
   input  logic              is_intr,
   input  logic              do_ret,
   input  logic              bad_ret,
   input  logic [VEC_W-1:0]  vec_off,
   input  logic              vec_skip,
   input  logic [AW-1:0]     cur_pc,
   input  logic              base_we,
   input  logic [AW-1:0]     base_wdata,
   input  logic              ctl_we,
   input  logic [DW-1:0]     ctl_wdata,
   output logic              swap,
   output logic [AW-1:0]     pc_o,
   output logic [AW-1:0]     npc_o,
   output logic              redirect_o,
   output logic [AW-1:0]     exc_addr_o,
   output logic              shadow_o,
   output logic              swap_err_o,
   output logic              bad_rti_o,
   output logic              irq_chk_o,
   output logic [AW-1:0]     base_o,
   output logic [DW-1:0]     ctl_o
);

   localparam logic [AW-1:0] STEP = AW'(4);

   logic          priv;
   logic          want_in, want_out, want_any, redundant;
   logic [AW-1:0] trap_pc, ret_pc;

   assign priv      = cur_pc[0];
   assign want_in   = take_trap && !priv;
   assign want_out  = do_ret && !exc_addr_o[0];
   assign want_any  = want_in || want_out;
   assign redundant = (want_in && shadow_o) || (want_out && !shadow_o);
   assign swap      = want_any && !redundant;
   assign trap_pc   = base_o + AW'(vec_off);
   assign ret_pc    = exc_addr_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_o       <= RESET_BASE + AW'(1);
         npc_o      <= RESET_BASE + AW'(1) + STEP;
         redirect_o <= 1'b0;
         exc_addr_o <= '0;
         shadow_o   <= 1'b1;
         swap_err_o <= 1'b0;
         bad_rti_o  <= 1'b0;
         irq_chk_o  <= 1'b0;
         base_o     <= RESET_BASE;
         ctl_o      <= CTL_INIT;
      end else begin
         redirect_o <= take_trap || do_ret;
         swap_err_o <= want_any && redundant;
         bad_rti_o  <= bad_ret;
         irq_chk_o  <= do_ret;
         if (swap) shadow_o <= want_in;
         if (take_trap) begin
            pc_o  <= trap_pc;
            npc_o <= trap_pc + STEP;
            if (!(is_intr && priv))
               exc_addr_o <= vec_skip ? cur_pc + STEP : cur_pc;
         end else if (do_ret) begin
            pc_o  <= ret_pc;
            npc_o <= ret_pc + STEP;
         end
         if (base_we) base_o <= base_wdata;
         if (ctl_we)  ctl_o  <= ctl_wdata;
      end
   end

endmodule

// File: rtl/trap_steer.sv
module trap_steer
   import trap_pkg::*;
#(
   parameter int unsigned      AW         = 32,
   parameter int unsigned      DW         = 32,
   parameter int unsigned      NREG       = 32,
   parameter logic [AW-1:0]    RESET_BASE = 32'h0000_4000,
   parameter logic [DW-1:0]    CTL_INIT   = 32'h6,
   localparam int unsigned     RW         = $clog2(NREG)
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           flt_valid,
   input  logic [4:0]     flt_code,
   input  logic [AW-1:0]  cur_pc,
   input  logic           rti_req,
   input  logic           base_we,
   input  logic [AW-1:0]  base_wdata,
   input  logic           ctl_we,
   input  logic [DW-1:0]  ctl_wdata,
   input  logic           rf_we,
   input  logic [RW-1:0]  rf_waddr,
   input  logic [DW-1:0]  rf_wdata,
   input  logic [RW-1:0]  rf_raddr,
   output logic [DW-1:0]  rf_rdata,
   output logic [AW-1:0]  pc_o,
   output logic [AW-1:0]  npc_o,
   output logic           redirect_o,
   output logic [AW-1:0]  exc_addr_o,
   output logic           shadow_o,
   output logic           swap_err_o,
   output logic           bad_rti_o,
   output logic           irq_chk_o,
   output logic [AW-1:0]  base_o,
   output logic [DW-1:0]  ctl_o
);

   if (AW < VEC_W) begin : g_bad_aw
      $error("trap_steer: AW must hold the widest vector offset");
   end
   if (NREG < 26) begin : g_bad_nreg
      $error("trap_steer: NREG must include every redirected register");
   end

   logic          accepted, take_trap, do_ret, bad_ret, swap, vec_skip;
   fault_e        sel_code;
   logic [VEC_W-1:0] vec_off;

   assign accepted  = flt_valid && code_known(flt_code);
   assign do_ret    = rti_req && !accepted && cur_pc[0];
   assign bad_ret   = rti_req && !accepted && !cur_pc[0];
   assign take_trap = accepted || bad_ret;
   assign sel_code  = accepted ? fault_e'(flt_code) : FC_UNIMPL;

   trap_vector i_vec (
      .code   (sel_code),
      .offset (vec_off),
      .skip   (vec_skip)
   );

   trap_seq #(
      .AW(AW), .DW(DW), .RESET_BASE(RESET_BASE), .CTL_INIT(CTL_INIT)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_trap  (take_trap),
      .is_intr    (sel_code == FC_INTR),
      .do_ret     (do_ret),
      .bad_ret    (bad_ret),
      .vec_off    (vec_off),
      .vec_skip   (vec_skip),
      .cur_pc     (cur_pc),
      .base_we    (base_we),
      .base_wdata (base_wdata),
      .ctl_we     (ctl_we),
      .ctl_wdata  (ctl_wdata),
      .swap       (swap),
      .pc_o       (pc_o),
      .npc_o      (npc_o),
      .redirect_o (redirect_o),
      .exc_addr_o (exc_addr_o),
      .shadow_o   (shadow_o),
      .swap_err_o (swap_err_o),
      .bad_rti_o  (bad_rti_o),
      .irq_chk_o  (irq_chk_o),
      .base_o     (base_o),
      .ctl_o      (ctl_o)
   );

   shadow_bank #(.DW(DW), .NREG(NREG)) i_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .swap  (swap),
      .we    (rf_we),
      .waddr (rf_waddr),
      .wdata (rf_wdata),
      .raddr (rf_raddr),
      .rdata (rf_rdata)
   );

endmodule

// File: rtl/trap_steer_chk.sv
module trap_steer_chk #(
   parameter int unsigned AW = 32
)(
   input logic           clk,
   input logic           rst_n,
   input logic           flt_valid,
   input logic [4:0]     flt_code,
   input logic [AW-1:0]  cur_pc,
   input logic           rti_req,
   input logic [AW-1:0]  pc_o,
   input logic [AW-1:0]  npc_o,
   input logic           redirect_o,
   input logic [AW-1:0]  exc_addr_o,
   input logic           shadow_o,
   input logic           swap_err_o,
   input logic           bad_rti_o,
   input logic           irq_chk_o
);

   // R2
   next_pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> (npc_o == pc_o + AW'(4)));

   // R4
   intr_keeps_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && flt_code == 5'd4 && cur_pc[0]) |=> $stable(exc_addr_o));

   // R5
   enter_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && flt_code >= 5'd1 && flt_code <= 5'd16 && !cur_pc[0]) |=> shadow_o);

   // R6
   ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rti_req && !flt_valid && cur_pc[0]) |=> (pc_o == $past(exc_addr_o)) && irq_chk_o);

   // R7
   bad_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rti_req && !flt_valid && !cur_pc[0]) |=> bad_rti_o && !irq_chk_o);

   // R8
   swap_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swap_err_o |-> (shadow_o == $past(shadow_o)));

   // R9
   null_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && flt_code == 5'd0 && !rti_req) |=> !redirect_o);

endmodule

bind trap_steer trap_steer_chk #(.AW(AW)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flt_valid  (flt_valid),
   .flt_code   (flt_code),
   .cur_pc     (cur_pc),
   .rti_req    (rti_req),
   .pc_o       (pc_o),
   .npc_o      (npc_o),
   .redirect_o (redirect_o),
   .exc_addr_o (exc_addr_o),
   .shadow_o   (shadow_o),
   .swap_err_o (swap_err_o),
   .bad_rti_o  (bad_rti_o),
   .irq_chk_o  (irq_chk_o)
);

// File: tb/test_trap_steer.sv
module test_trap_steer;

   localparam int unsigned AW = 32;
   localparam int unsigned DW = 32;
   localparam int unsigned RW = 5;
   localparam logic [31:0] BASE = 32'h0000_4000;

   // {code, skip, offset}
   localparam logic [31:0] TBL [16] = '{
      {8'd1,  8'd0, 16'h0001}, {8'd2,  8'd0, 16'h0401},
      {8'd3,  8'd1, 16'h0501}, {8'd4,  8'd0, 16'h0101},
      {8'd5,  8'd0, 16'h0201}, {8'd6,  8'd0, 16'h0281},
      {8'd7,  8'd0, 16'h0301}, {8'd8,  8'd0, 16'h0381},
      {8'd9,  8'd0, 16'h0381}, {8'd10, 8'd0, 16'h0181},
      {8'd11, 8'd0, 16'h0181}, {8'd12, 8'd0, 16'h0081},
      {8'd13, 8'd0, 16'h0481}, {8'd14, 8'd0, 16'h0581},
      {8'd15, 8'd1, 16'h2001}, {8'd16, 8'd1, 16'h0501}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flt_valid = 1'b0;
   logic [4:0] flt_code = '0;
   logic [AW-1:0] cur_pc = '0;
   logic rti_req = 1'b0;
   logic base_we = 1'b0;
   logic [AW-1:0] base_wdata = '0;
   logic ctl_we = 1'b0;
   logic [DW-1:0] ctl_wdata = '0;
   logic rf_we = 1'b0;
   logic [RW-1:0] rf_waddr = '0;
   logic [DW-1:0] rf_wdata = '0;
   logic [RW-1:0] rf_raddr = '0;
   logic [DW-1:0] rf_rdata;
   logic [AW-1:0] pc_o, npc_o, exc_addr_o, base_o;
   logic [DW-1:0] ctl_o;
   logic redirect_o, shadow_o, swap_err_o, bad_rti_o, irq_chk_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   trap_steer i_trap_steer (
      .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_code(flt_code),
      .cur_pc(cur_pc), .rti_req(rti_req), .base_we(base_we), .base_wdata(base_wdata),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
      .rf_wdata(rf_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
      .pc_o(pc_o), .npc_o(npc_o), .redirect_o(redirect_o), .exc_addr_o(exc_addr_o),
      .shadow_o(shadow_o), .swap_err_o(swap_err_o), .bad_rti_o(bad_rti_o),
      .irq_chk_o(irq_chk_o), .base_o(base_o), .ctl_o(ctl_o)
   );

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic cyc(input logic fv, input logic [4:0] fc, input logic [31:0] cp, input logic rr);
      @(negedge clk);
      flt_valid = fv; flt_code = fc; cur_pc = cp; rti_req = rr;
      @(negedge clk);
      flt_valid = 1'b0; rti_req = 1'b0; rf_we = 1'b0; base_we = 1'b0; ctl_we = 1'b0;
   endtask

   task automatic wr(input int idx, input logic [31:0] d);
      @(negedge clk);
      rf_we = 1'b1; rf_waddr = RW'(idx); rf_wdata = d;
      @(negedge clk);
      rf_we = 1'b0;
   endtask

   task automatic rd(input string req, input int idx, input logic [31:0] exp);
      rf_raddr = RW'(idx);
      #1;
      chk(req, rf_rdata, exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      logic [31:0] exp_exc;
      do_reset();
      // R1 reset state
      chk("R1 pc", pc_o, BASE + 1);
      chk("R1 npc", npc_o, BASE + 5);
      chk("R1 shadow", shadow_o, 1);
      chk("R1 base", base_o, BASE);
      chk("R1 ctl", ctl_o, 6);
      chk("R1 exc", exc_addr_o, 0);
      chk("R1 pulses", {redirect_o, swap_err_o, bad_rti_o, irq_chk_o}, 0);

      // R2/R3/R4 table walk from privileged PCs
      exp_exc = 32'h0;
      for (int i = 0; i < 16; i++) begin
         logic [31:0] cp;
         cp = 32'h1001 + 32'(i) * 32;
         cyc(1'b1, TBL[i][28:24], cp, 1'b0);
         if (TBL[i][31:24] != 8'd4)
            exp_exc = (TBL[i][23:16] != 0) ? cp + 4 : cp;
         chk("R2 pc", pc_o, BASE + {16'h0, TBL[i][15:0]});
         chk("R2 npc", npc_o, BASE + {16'h0, TBL[i][15:0]} + 4);
         chk("R3 R4 exc", exc_addr_o, exp_exc);
      end
      chk("R5 priv trap no swap", shadow_o, 1);

      // directed: shadow swapping and returns
      do_reset();
      wr(9, 32'hAAAA_0009); wr(25, 32'hCCCC_0025);
      wr(7, 32'hDDDD_0007); wr(15, 32'hEEEE_0015);
      cyc(1'b0, 5'd0, 32'h0000_4001, 1'b1);
      chk("R6 ret pc", pc_o, 32'h0);
      chk("R6 ret npc", npc_o, 32'h4);
      chk("R6 irq_chk", irq_chk_o, 1);
      chk("R6 swap out", shadow_o, 0);
      rd("R11 r9 swapped out", 9, 32'h0);
      rd("R11 r25 swapped out", 25, 32'h0);
      rd("R11 r7 untouched", 7, 32'hDDDD_0007);
      rd("R11 r15 untouched", 15, 32'hEEEE_0015);

      wr(9, 32'hBBBB_0009);
      cyc(1'b0, 5'd0, 32'h0000_0100, 1'b1);
      chk("R7 bad_rti", bad_rti_o, 1);
      chk("R7 irq_chk", irq_chk_o, 0);
      chk("R7 pc", pc_o, BASE + 32'h481);
      chk("R7 exc", exc_addr_o, 32'h100);
      chk("R5 swap in", shadow_o, 1);
      rd("R5 r9 shadow value", 9, 32'hAAAA_0009);
      rd("R5 r25 shadow value", 25, 32'hCCCC_0025);

      cyc(1'b1, 5'd15, 32'h0000_1235, 1'b0);
      chk("R3 privcall skip", exc_addr_o, 32'h1239);
      chk("R5 priv no swap err", swap_err_o, 0);

      cyc(1'b1, 5'd2, 32'h0000_2000, 1'b0);
      chk("R8 swap_err in", swap_err_o, 1);
      chk("R8 shadow kept", shadow_o, 1);
      rd("R8 r9 kept", 9, 32'hAAAA_0009);
      chk("R3 exc", exc_addr_o, 32'h2000);

      cyc(1'b0, 5'd0, 32'h0000_0011, 1'b1);
      chk("R6 pc", pc_o, 32'h2000);
      chk("R6 shadow out", shadow_o, 0);
      rd("R6 r9 normal", 9, 32'hBBBB_0009);

      cyc(1'b0, 5'd0, 32'h0000_0011, 1'b1);
      chk("R8 swap_err out", swap_err_o, 1);
      chk("R8 shadow still off", shadow_o, 0);
      rd("R8 r9 unchanged", 9, 32'hBBBB_0009);

      cyc(1'b1, 5'd1, 32'h0000_3001, 1'b0);
      cyc(1'b0, 5'd0, 32'h0000_0011, 1'b1);
      chk("R6 odd ret pc", pc_o, 32'h3001);
      chk("R6 odd ret keeps shadow", shadow_o, 0);
      chk("R6 odd ret no err", swap_err_o, 0);

      // R9 priority and ignored codes
      cyc(1'b1, 5'd7, 32'h0000_0021, 1'b1);
      chk("R9 fault wins pc", pc_o, BASE + 32'h301);
      chk("R9 fault wins irq", irq_chk_o, 0);
      cyc(1'b1, 5'd0, 32'h0000_0041, 1'b0);
      chk("R9 code0 redirect", redirect_o, 0);
      chk("R9 code0 pc", pc_o, BASE + 32'h301);
      cyc(1'b1, 5'd20, 32'h0000_0041, 1'b0);
      chk("R9 code20 redirect", redirect_o, 0);
      chk("R9 code20 exc", exc_addr_o, 32'h21);

      // R10 base and control writes
      @(negedge clk);
      base_we = 1'b1; base_wdata = 32'h0000_8000;
      ctl_we = 1'b1; ctl_wdata = 32'h0000_00A5;
      @(negedge clk);
      base_we = 1'b0; ctl_we = 1'b0;
      chk("R10 base", base_o, 32'h8000);
      chk("R10 ctl", ctl_o, 32'hA5);
      cyc(1'b1, 5'd13, 32'h0000_0051, 1'b0);
      chk("R10 new base used", pc_o, 32'h8481);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule